// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for a processor pipeline. A pipeline stage presents a virtual address and says whether the access is a load or a store. Every entry compares its virtual page number in parallel. On a hit, the physical address is formed in the same cycle from the cached frame number and the untranslated 13-bit page offset. When a probe finds no valid entry it raises a miss indication, so the translation can be fetched from memory. A store that hits an entry with writes disabled raises a separate protection indication and returns no address.

Privileged software or a walker installs entries through a fill port. Hardware picks the slot. It reuses a slot with the same page number if one exists. Otherwise it takes the lowest-numbered empty slot. When the buffer is full, it uses a round-robin pointer that never lands on the entry used most recently. Each entry keeps a reference bit and a dirty bit. A successful access updates these bits, and they are reported on a hit. A flush input empties the whole buffer in one cycle for context switches.

Top module: `xlat_buf`

## Requirements
- R1: The buffer holds 48 translations in any slots. A load or store probe whose page number (address bits 31:13) matches a valid entry, and which is not a protection failure, asserts hit_o in the same cycle. In that cycle pa_o = {frame, probe address bits 12:0}.
- R2: A probe that matches no valid entry asserts miss_o, with hit_o low and pa_o zero.
- R3: A store probe (probe_store_i=1) that matches an entry whose write-enable bit is 0 asserts prot_fault_o, keeps hit_o low and pa_o zero, and leaves that entry's dirty and reference bits unchanged.
- R4: A successful probe sets the entry's reference bit at the next clock edge. On a hit, ref_o shows the bit's value before that probe.
- R5: A successful store sets the entry's dirty bit at the next clock edge. On a hit, dirty_o shows the bit's value before that probe.
- R6: A fill (fill_valid_i=1) writes the page number, frame and write-enable bit into an entry, makes it valid and clears its dirty and reference bits. The translation is usable from the next cycle.
- R7: A fill whose page number matches a valid entry overwrites that entry, so no other translation is displaced.
- R8: While any entry is invalid, a fill of a new page takes the lowest-numbered invalid entry and evicts nothing.
- R9: When all entries are valid, a fill of a new page evicts the entry at the round-robin pointer. If that entry is the most recently hit or filled one, the next entry is evicted instead. The pointer then moves to the entry after the evicted one. The pointer and the last-used index both reset to 0.
- R10: flush_i invalidates every entry at the next clock edge and takes priority over a fill in the same cycle, which is dropped.
- R11: At most one of hit_o, miss_o and prot_fault_o is high. All three are low while probe_valid_i is low.
- R12: After reset, every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| probe_valid_i | input | 1 | A probe is presented this cycle |
| probe_va_i | input | 32 | Virtual address of the probe |
| probe_store_i | input | 1 | 1 = store access, 0 = load |
| hit_o | output | 1 | Translation succeeded |
| miss_o | output | 1 | No valid entry matched |
| prot_fault_o | output | 1 | Store to a write-disabled entry |
| pa_o | output | 32 | Physical address on a hit, otherwise zero |
| ref_o | output | 1 | Reference bit of the hit entry before this probe |
| dirty_o | output | 1 | Dirty bit of the hit entry before this probe |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 19 | Virtual page number to install |
| fill_pfn_i | input | 19 | Physical frame number to install |
| fill_wr_en_i | input | 1 | Write-enable bit of the installed entry |
| flush_i | input | 1 | Invalidate all entries |

## Verification
Directed sequences probe the same page repeatedly with loads and then stores. These show whether the reference and dirty bits are set and reported at the right times, and whether a faulting store leaves them alone. A refill of a resident page with writes disabled separates in-place replacement from eviction. Filling all 48 slots and then adding one more shows whether empty slots are used first and which entry the not-last-used pointer evicts. A random mix of loads, stores, fills and flushes, drawn from a page pool larger than the buffer, is compared against a bench model. The mix includes fills that arrive together with a flush, so that miss, hit and fault outcomes and the replacement order are checked over long histories.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned OFS_W = 13;

  typedef struct packed {
    logic valid;
    logic wr_en;
    logic dirty;
    logic refd;
  } xlat_flags_t;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int unsigned N     = 48,
  parameter int unsigned KEY_W = 19,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [KEY_W-1:0] keys_i [N],
  input  logic [N-1:0]     valid_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (keys_i[g] == key_i);
  end

  // matches are one-hot by construction of the fill path
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) idx_o = idx_o | IDX_W'(i);
  end

  assign any_o = |match;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned N = 48,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             evict_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             full_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_q, last_q, free_idx, rr_pick;
  logic             free_any;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  always_comb begin
    rr_pick = rr_q;
    if (rr_q == last_q) rr_pick = (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  assign full_o   = !free_any;
  assign victim_o = free_any ? free_idx : rr_pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q   <= '0;
      last_q <= '0;
    end else begin
      if (touch_i) last_q <= touch_idx_i;
      if (evict_i) rr_q <= (rr_pick == LAST) ? '0 : rr_pick + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int unsigned N    = 48,
  parameter int unsigned VA_W = 32,
  parameter int unsigned PA_W = 32,
  localparam int unsigned OFS_W = xlat_pkg::OFS_W,
  localparam int unsigned VPN_W = VA_W - OFS_W,
  localparam int unsigned PFN_W = PA_W - OFS_W,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             probe_valid_i,
  input  logic [VA_W-1:0]  probe_va_i,
  input  logic             probe_store_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic             prot_fault_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             ref_o,
  output logic             dirty_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_wr_en_i,
  input  logic             flush_i
);
  import xlat_pkg::*;

  logic [VPN_W-1:0] tag_q [N];
  logic [PFN_W-1:0] pfn_q [N];
  xlat_flags_t      flg_q [N];
  logic [N-1:0]     valid_vec;

  for (genvar g = 0; g < N; g++) begin : g_vld
    assign valid_vec[g] = flg_q[g].valid;
  end

  logic             p_any, f_any, full;
  logic [IDX_W-1:0] p_idx, f_idx, victim, fill_idx;

  xlat_cam #(.N(N), .KEY_W(VPN_W)) u_probe_cam (
    .keys_i(tag_q), .valid_i(valid_vec), .key_i(probe_va_i[VA_W-1:OFS_W]),
    .any_o(p_any), .idx_o(p_idx)
  );

  xlat_cam #(.N(N), .KEY_W(VPN_W)) u_fill_cam (
    .keys_i(tag_q), .valid_i(valid_vec), .key_i(fill_vpn_i),
    .any_o(f_any), .idx_o(f_idx)
  );

  logic raw_hit, fault, ok, fill_en;

  assign raw_hit  = probe_valid_i && p_any;
  assign fault    = raw_hit && probe_store_i && !flg_q[p_idx].wr_en;
  assign ok       = raw_hit && !fault;
  assign fill_en  = fill_valid_i && !flush_i;
  assign fill_idx = f_any ? f_idx : victim;

  xlat_victim #(.N(N)) u_victim (
    .clk_i, .rst_ni,
    .valid_i    (valid_vec),
    .touch_i    (fill_en || ok),
    .touch_idx_i(fill_en ? fill_idx : p_idx),
    .evict_i    (fill_en && !f_any && full),
    .victim_o   (victim),
    .full_o     (full)
  );

  assign hit_o        = ok;
  assign miss_o       = probe_valid_i && !p_any;
  assign prot_fault_o = fault;
  assign pa_o         = ok ? {pfn_q[p_idx], probe_va_i[OFS_W-1:0]} : '0;
  assign ref_o        = ok && flg_q[p_idx].refd;
  assign dirty_o      = ok && flg_q[p_idx].dirty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        pfn_q[i] <= '0;
        flg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush_i) begin
          flg_q[i].valid <= 1'b0;
        end else if (fill_en && fill_idx == IDX_W'(i)) begin
          tag_q[i] <= fill_vpn_i;
          pfn_q[i] <= fill_pfn_i;
          flg_q[i] <= '{valid: 1'b1, wr_en: fill_wr_en_i, dirty: 1'b0, refd: 1'b0};
        end else if (ok && p_idx == IDX_W'(i)) begin
          flg_q[i].refd <= 1'b1;
          if (probe_store_i) flg_q[i].dirty <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFS_W = 13
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  probe_valid_i,
  input logic [VA_W-1:0]       probe_va_i,
  input logic                  hit_o,
  input logic                  miss_o,
  input logic                  prot_fault_o,
  input logic [PA_W-1:0]       pa_o,
  input logic                  fill_valid_i,
  input logic [VA_W-OFS_W-1:0] fill_vpn_i,
  input logic                  flush_i
);
  // R11
  outputs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, miss_o, prot_fault_o}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !probe_valid_i |-> !(hit_o || miss_o || prot_fault_o));

  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[OFS_W-1:0] == probe_va_i[OFS_W-1:0]);

  // R3
  fault_no_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> pa_o == '0);

  // R10
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !(hit_o || prot_fault_o));

  // R6
  fill_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i) ##1
    (probe_valid_i && probe_va_i[VA_W-1:OFS_W] == $past(fill_vpn_i))
    |-> (hit_o || prot_fault_o));
endmodule

bind xlat_buf xlat_buf_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
  .clk_i, .rst_ni, .probe_valid_i, .probe_va_i, .hit_o, .miss_o, .prot_fault_o,
  .pa_o, .fill_valid_i, .fill_vpn_i, .flush_i
);

// File: tb/tb_xlat_buf.sv
`timescale 1ns/1ps
module tb_xlat_buf;
  localparam int N = 48, VA_W = 32, PA_W = 32, OFS = 13;
  localparam int VPN_W = VA_W - OFS, PFN_W = PA_W - OFS;

  logic clk = 0, rst_n = 0;
  logic probe_valid = 0, probe_store = 0;
  logic [VA_W-1:0] probe_va = '0;
  logic hit, miss, flt, ref_b, dirty_b;
  logic [PA_W-1:0] pa;
  logic fill_valid = 0, fill_we = 0, flush = 0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;

  always #4 clk = ~clk;

  xlat_buf dut (
    .clk_i(clk), .rst_ni(rst_n), .probe_valid_i(probe_valid), .probe_va_i(probe_va),
    .probe_store_i(probe_store), .hit_o(hit), .miss_o(miss), .prot_fault_o(flt),
    .pa_o(pa), .ref_o(ref_b), .dirty_o(dirty_b), .fill_valid_i(fill_valid),
    .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn), .fill_wr_en_i(fill_we), .flush_i(flush)
  );

  int n_chk = 0, n_fail = 0, misses = 0;
  bit done = 0;

  logic [VPN_W-1:0] m_vpn [N];
  logic [PFN_W-1:0] m_pfn [N];
  bit m_v [N], m_we [N], m_d [N], m_r [N];
  int m_rr = 0, m_last = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input logic [VPN_W-1:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic probe(input logic [VPN_W-1:0] vpn, input logic [OFS-1:0] ofs,
                       input bit st, output bit was_miss);
    int idx;
    bit e_flt, e_ok;
    @(negedge clk);
    probe_valid = 1; probe_va = {vpn, ofs}; probe_store = st;
    #1;
    idx = m_find(vpn);
    was_miss = (idx < 0);
    e_flt = (idx >= 0) && st && !m_we[idx];
    e_ok  = (idx >= 0) && !e_flt;
    chk(miss == (idx < 0), "R2 miss", miss, idx < 0);
    chk(flt == e_flt, "R3 fault", flt, e_flt);
    chk(hit == e_ok, "R1 hit", hit, e_ok);
    if (e_ok) begin
      chk(pa == {m_pfn[idx], ofs}, "R1 pa", pa, {m_pfn[idx], ofs});
      chk(ref_b == m_r[idx], "R4 ref", ref_b, m_r[idx]);
      chk(dirty_b == m_d[idx], "R5 dirty", dirty_b, m_d[idx]);
    end else begin
      chk(pa == '0, "R2/R3 pa zero", pa, 0);
    end
    @(posedge clk);
    if (e_ok) begin
      m_r[idx] = 1;
      if (st) m_d[idx] = 1;
      m_last = idx;
    end
    #1 probe_valid = 0; probe_store = 0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                      input bit we, input bit fl);
    int idx, v;
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; fill_we = we; flush = fl;
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;   // R10: fill dropped
    end else begin
      idx = m_find(vpn);                          // R7
      if (idx < 0) begin
        v = m_free();                             // R8
        if (v < 0) begin                          // R9
          v = (m_rr == m_last) ? (m_rr + 1) % N : m_rr;
          m_rr = (v + 1) % N;
        end
        idx = v;
      end
      m_v[idx] = 1; m_vpn[idx] = vpn; m_pfn[idx] = pfn; m_we[idx] = we;
      m_d[idx] = 0; m_r[idx] = 0; m_last = idx;  // R6
    end
    #1 fill_valid = 0; flush = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); for (int i = 0; i < N; i++) m_v[i] = 0;
    #1 flush = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit mm;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_we[i] = 0; m_d[i] = 0; m_r[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R11: idle outputs
    @(negedge clk); #1;
    chk(!(hit || miss || flt), "R11 idle", {hit, miss, flt}, 0);
    // R12: empty after reset
    probe(19'h5, 13'h10, 0, mm);
    chk(mm, "R12 empty after reset", !mm, 0);

    // R6 / R4 / R5
    fill(19'h5, 19'h1234, 1, 0);
    probe(19'h5, 13'h1abc, 0, mm);
    probe(19'h5, 13'h0007, 0, mm);
    probe(19'h5, 13'h0100, 1, mm);
    probe(19'h5, 13'h0101, 1, mm);
    // R7 overwrite in place, write disabled; R3 fault leaves bits
    fill(19'h5, 19'h0777, 0, 0);
    probe(19'h5, 13'h0002, 0, mm);
    probe(19'h5, 13'h0003, 1, mm);
    probe(19'h5, 13'h0004, 0, mm);

    // R8: 48 distinct pages evict nothing
    do_flush();
    for (int i = 0; i < N; i++) fill(19'h100 + 19'(i), 19'h4000 + 19'(i), 1, 0);
    misses = 0;
    for (int i = 0; i < N; i++) begin
      probe(19'h100 + 19'(i), 13'h0, 0, mm);
      if (mm) misses++;
    end
    chk(misses == 0, "R8 no eviction while free", misses, 0);
    // R9: one more page evicts exactly one entry
    fill(19'h7ff, 19'h7ff, 1, 0);
    misses = 0;
    for (int i = 0; i < N; i++) begin
      probe(19'h100 + 19'(i), 13'h0, 0, mm);
      if (mm) misses++;
    end
    chk(misses == 1, "R9 single eviction", misses, 1);
    probe(19'h7ff, 13'h55, 0, mm);

    // R10: flush beats same-cycle fill
    fill(19'h9, 19'h9, 1, 1);
    probe(19'h9, 13'h0, 0, mm);
    probe(19'h100, 13'h0, 0, mm);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int op = $urandom_range(0, 99);
      logic [VPN_W-1:0] vpn = 19'h200 + 19'($urandom_range(0, 63));
      if (op < 60)
        probe(vpn, 13'($urandom), $urandom_range(0, 1), mm);
      else if (op < 98)
        fill(vpn, 19'($urandom), $urandom_range(0, 3) != 0, 0);
      else
        fill(vpn, 19'($urandom), 1, $urandom_range(0, 1));
    end

    finish_run();
  end
endmodule